// File: doc/BRIEF.md
# Burst Word Serial Transmitter

This block sends fixed-width control words from one processor to another over a synchronous serial link. It has one frame pulse output and several parallel data lanes. There is no frame period. A frame pulse goes out only when there is a word to send. That happens when the previous slot has ended and every lane marked as enabled holds a fresh word. Each frame pulse starts exactly one slot per lane. The slot is sent most significant bit first, and the first bit can follow the frame pulse after 0, 1 or 2 bit times.

The bit clock is the block clock `clk`, and all outputs change on its rising edge. A receiver samples them on the falling edge. Software or a local controller loads each lane through its own write strobe and watches the per-lane empty flags to know when a lane can take its next word. When all lanes are refilled before a slot ends, the next frame pulse follows the last bit with no gap. This gives a continuous stream when the delay is zero.

Top module: `burst_word_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `frame_o` is 0, every `ser_o` bit is 0 and every `empty_o` bit is 1.
- R2: Launch condition. At least one bit of `lane_en` must be 1, and the block must be idle or in the last bit of a slot. Every lane with its `lane_en` bit at 1 must hold a word. When all of this is true at a rising edge, `frame_o` is 1 in the cycle after that edge. A word written at edge E can therefore raise `frame_o` at the earliest in the cycle after edge E+1.
- R3: `frame_o` is high for exactly one bit time per slot, and one slot follows each pulse.
- R4: Bit timing. Let `dly_sel` be 0, 1 or 2, giving a delay d. The first data bit appears d cycles after the `frame_o` cycle. SLOT_W bits follow on consecutive cycles, most significant bit first. The code 3 acts as 2.
- R5: `ser_o` is 0 at these times: while idle, in the delay cycles, and after the last bit until the next slot's data. A lane whose `lane_en` bit was 0 when the slot was launched stays at 0 for the whole slot.
- R6: No frame pulse is issued while any enabled lane is empty, however many cycles pass. A lane whose `lane_en` bit is 0 neither blocks nor causes a launch. With `lane_en` all zero, nothing is ever launched.
- R7: A write strobe clears that lane's `empty_o` bit at the next edge. The launch edge sets `empty_o` for every enabled lane. If a lane is written at the same edge as the launch, its old word is sent and the new word stays, so `empty_o` remains 0.
- R8: `dly_sel` is sampled only at the launch edge. Changing it during a slot does not alter that slot's timing.
- R9: If all enabled lanes are refilled before a slot ends, the next `frame_o` pulse comes in the cycle right after the last data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | LANES | Lanes that take part in the next launch |
| dly_sel | input | 2 | Frame-to-first-bit delay code (0, 1, 2; 3 acts as 2) |
| wr_strobe | input | LANES | Per-lane write strobe for the word buffers |
| wr_data | input | LANES*SLOT_W | Per-lane words, lane i at bits [i*SLOT_W +: SLOT_W] |
| frame_o | output | 1 | One-bit-wide frame pulse |
| ser_o | output | LANES | Serial data, one bit per lane |
| empty_o | output | LANES | Per-lane buffer-empty flags |

## Verification
The words on the two lanes are made deliberately different, so a swapped or wrong-order bit shows in the captured word. Every delay code, including the out-of-range one, is run so that an off-by-one in the delay counter shows up as a shifted word. Runs where only some lanes are loaded, or some are disabled, or all are disabled, separate a correct readiness check from one that ignores the enable mask. A write landing on the launch edge, a reload during a slot, and a delay change in mid-slot separate correct buffer hand-off and correct sampling of the delay from logic that loses a word, adds a gap, or re-times a slot that is already running.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  localparam int unsigned DLY_W = 2;

  // Delay code 3 is folded onto the longest legal delay.
  function automatic logic [DLY_W-1:0] clamp_delay(input logic [DLY_W-1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/bwt_lane_buffer.sv
module bwt_lane_buffer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic [W-1:0] data_o,
  output logic         full_o
);

  logic [W-1:0] word_q;
  logic         full_q;

  // Storage has no reset so it can map onto plain registers or RAM.
  always_ff @(posedge clk) begin
    if (wr) word_q <= wdata;
  end

  // A write wins over a take at the same edge: the taken word is the old one.
  always_ff @(posedge clk) begin
    if (rst)       full_q <= 1'b0;
    else if (wr)   full_q <= 1'b1;
    else if (take) full_q <= 1'b0;
  end

  assign data_o = word_q;
  assign full_o = full_q;

endmodule

// File: rtl/bwt_sequencer.sv
module bwt_sequencer
  import bwt_pkg::*;
#(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned LANES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] full,
  input  logic [DLY_W-1:0] dly_code,
  output logic             launch_o,
  output logic             shift_o,
  output logic             data_next_o,
  output logic [LANES-1:0] en_next_o,
  output logic             frame_o,
  output logic             busy_o
);

  localparam int unsigned CW = $clog2(SLOT_W + 3);

  logic             busy_q, busy_n;
  logic [CW-1:0]    pos_q, pos_n;
  logic [DLY_W-1:0] dly_q, dly_n;
  logic [LANES-1:0] en_q, en_n;
  logic             frame_q;
  logic [CW-1:0]    end_pos;
  logic             last, lanes_ok, launch;

  assign end_pos  = CW'(SLOT_W - 1) + CW'(dly_q);
  assign last     = busy_q && (pos_q == end_pos);
  assign lanes_ok = (&(full | ~lane_en)) && (|lane_en);
  assign launch   = (!busy_q || last) && lanes_ok;

  always_comb begin
    busy_n = busy_q;
    pos_n  = pos_q;
    dly_n  = dly_q;
    en_n   = en_q;
    if (launch) begin
      busy_n = 1'b1;
      pos_n  = '0;
      dly_n  = clamp_delay(dly_code);
      en_n   = lane_en;
    end else if (last) begin
      busy_n = 1'b0;
      pos_n  = '0;
    end else if (busy_q) begin
      pos_n  = pos_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pos_q   <= '0;
      dly_q   <= '0;
      en_q    <= '0;
      frame_q <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      pos_q   <= pos_n;
      dly_q   <= dly_n;
      en_q    <= en_n;
      frame_q <= launch;
    end
  end

  assign launch_o    = launch;
  assign shift_o     = busy_q && (pos_q >= CW'(dly_q));
  assign data_next_o = busy_n && (pos_n >= CW'(dly_n));
  assign en_next_o   = en_n;
  assign frame_o     = frame_q;
  assign busy_o      = busy_q;

endmodule

// File: rtl/bwt_lane_shifter.sv
module bwt_lane_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         out_en,
  output logic         ser_o
);

  logic [W-1:0] sr_q, sr_n;
  logic         ser_q;

  always_comb begin
    if (load)       sr_n = load_word;
    else if (shift) sr_n = {sr_q[W-2:0], 1'b0};
    else            sr_n = sr_q;
  end

  always_ff @(posedge clk) begin
    sr_q <= sr_n;
  end

  // Registered serial bit: next cycle's bit is chosen from the next shifter state.
  always_ff @(posedge clk) begin
    if (rst) ser_q <= 1'b0;
    else     ser_q <= out_en ? sr_n[W-1] : 1'b0;
  end

  assign ser_o = ser_q;

endmodule

// File: rtl/burst_word_tx.sv
module burst_word_tx
  import bwt_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned SLOT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        lane_en,
  input  logic [DLY_W-1:0]        dly_sel,
  input  logic [LANES-1:0]        wr_strobe,
  input  logic [LANES*SLOT_W-1:0] wr_data,
  output logic                    frame_o,
  output logic [LANES-1:0]        ser_o,
  output logic [LANES-1:0]        empty_o
);

  logic             launch, shift_now, data_next, seq_busy;
  logic [LANES-1:0] full, en_next;

  bwt_sequencer #(.SLOT_W(SLOT_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .lane_en    (lane_en),
    .full       (full),
    .dly_code   (dly_sel),
    .launch_o   (launch),
    .shift_o    (shift_now),
    .data_next_o(data_next),
    .en_next_o  (en_next),
    .frame_o    (frame_o),
    .busy_o     (seq_busy)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SLOT_W-1:0] word;
    logic              take;

    assign take = launch && lane_en[i];

    bwt_lane_buffer #(.W(SLOT_W)) u_buf (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_strobe[i]),
      .wdata (wr_data[i*SLOT_W +: SLOT_W]),
      .take  (take),
      .data_o(word),
      .full_o(full[i])
    );

    bwt_lane_shifter #(.W(SLOT_W)) u_shf (
      .clk      (clk),
      .rst      (rst),
      .load     (take),
      .load_word(word),
      .shift    (shift_now),
      .out_en   (data_next && en_next[i]),
      .ser_o    (ser_o[i])
    );
  end

  assign empty_o = ~full;

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_en,
  input logic             frame_o,
  input logic [LANES-1:0] ser_o,
  input logic [LANES-1:0] empty_o,
  input logic             busy
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!frame_o && ser_o == '0 && empty_o == '1));

  // R3
  frame_width_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o);

  // R6
  launch_ready_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> $past(&((~empty_o) | (~lane_en))));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ser_o == '0 && !frame_o));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R7
    empty_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(empty_o[i]) |-> frame_o);
  end

endmodule

bind burst_word_tx bwt_checker #(.LANES(LANES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .lane_en(lane_en),
  .frame_o(frame_o),
  .ser_o  (ser_o),
  .empty_o(empty_o),
  .busy   (seq_busy)
);

// File: tb/tb_burst_word_tx.sv
module tb_burst_word_tx;

  localparam int CLK_P = 10;
  localparam int LN    = 2;
  localparam int SW    = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LN-1:0]    lane_en = '1;
  logic [1:0]       dly_sel = '0;
  logic [LN-1:0]    wr_strobe = '0;
  logic [LN*SW-1:0] wr_data = '0;
  logic             frame_o;
  logic [LN-1:0]    ser_o, empty_o;
  logic [LN-1:0]    emp_at_frame;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_word_tx #(.LANES(LN), .SLOT_W(SW)) dut (
    .clk(clk), .rst(rst), .lane_en(lane_en), .dly_sel(dly_sel),
    .wr_strobe(wr_strobe), .wr_data(wr_data),
    .frame_o(frame_o), .ser_o(ser_o), .empty_o(empty_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives a write across the next rising edge.
  task automatic write_lanes(input logic [LN-1:0] mask, input logic [SW-1:0] w0, input logic [SW-1:0] w1);
    wr_strobe = mask;
    wr_data   = {w1, w0};
    @(negedge clk);
    wr_strobe = '0;
  endtask

  // Called at the negedge one cycle before the expected frame pulse.
  task automatic expect_slot(input int d, input logic [SW-1:0] e0, input logic [SW-1:0] e1,
                             input bit use_mid, input logic [1:0] mid, input string req);
    logic [SW-1:0] g0, g1;
    int fbad, zbad;
    g0 = '0; g1 = '0; fbad = 0; zbad = 0;
    chk(frame_o == 1'b0, "R2 no early frame", 64'(frame_o), 64'd0);
    for (int k = 0; k < d + SW; k++) begin
      @(negedge clk);
      if (k == 0) emp_at_frame = empty_o;
      if (use_mid && k == 1) dly_sel = mid;
      if (frame_o != (k == 0)) fbad++;
      if (k < d) begin
        if (ser_o != '0) zbad++;
      end else begin
        g0 = {g0[SW-2:0], ser_o[0]};
        g1 = {g1[SW-2:0], ser_o[1]};
      end
    end
    chk(fbad == 0, "R3 single frame pulse", 64'(fbad), 64'd0);
    chk(zbad == 0, "R5 zero during delay", 64'(zbad), 64'd0);
    chk(g0 == e0, {req, " lane0"}, 64'(g0), 64'(e0));
    chk(g1 == e1, {req, " lane1"}, 64'(g1), 64'(e1));
  endtask

  task automatic idle_check(input int n, input string req);
    int hits;
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (frame_o || ser_o != '0) hits++;
    end
    chk(hits == 0, req, 64'(hits), 64'd0);
  endtask

  task automatic t_reset;
    chk(frame_o == 0 && ser_o == '0 && empty_o == 2'b11, "R1 reset state",
        64'({frame_o, ser_o, empty_o}), 64'b00011);
  endtask

  task automatic t_basic;
    dly_sel = 2'd0;
    write_lanes(2'b11, 16'hA5C3, 16'h1234);
    chk(empty_o == 2'b00, "R7 cleared by write", 64'(empty_o), 64'd0);
    expect_slot(0, 16'hA5C3, 16'h1234, 1'b0, 2'd0, "R4 delay0");
    chk(emp_at_frame == 2'b11, "R7 set at launch", 64'(emp_at_frame), 64'd3);
    idle_check(12, "R5 idle after slot");
  endtask

  task automatic t_delay(input logic [1:0] code, input int d, input string req);
    dly_sel = code;
    write_lanes(2'b11, 16'h8001 ^ 16'(d * 16'h0F0F), 16'h7E5A);
    expect_slot(d, 16'h8001 ^ 16'(d * 16'h0F0F), 16'h7E5A, 1'b0, 2'd0, req);
    idle_check(4, "R5 idle after delayed slot");
  endtask

  task automatic t_partial;
    dly_sel = 2'd0;
    write_lanes(2'b01, 16'hC0DE, 16'hFFFF);
    idle_check(30, "R6 one enabled lane empty");
    chk(empty_o == 2'b10, "R6 lane0 held", 64'(empty_o), 64'd2);
    write_lanes(2'b10, 16'h0000, 16'hBEEF);
    expect_slot(0, 16'hC0DE, 16'hBEEF, 1'b0, 2'd0, "R6 fires once complete");
    idle_check(3, "R5 idle");
  endtask

  task automatic t_disabled;
    lane_en = 2'b01;
    write_lanes(2'b10, 16'h0000, 16'h5555);
    idle_check(10, "R6 disabled lane does not launch");
    write_lanes(2'b01, 16'h3C96, 16'h0000);
    expect_slot(0, 16'h3C96, 16'h0000, 1'b0, 2'd0, "R5 disabled lane silent");
    idle_check(3, "R5 idle");
    lane_en = 2'b11;
  endtask

  task automatic t_coincide;
    dly_sel = 2'd0;
    write_lanes(2'b11, 16'h1111, 16'h2222);
    wr_strobe = 2'b01;
    wr_data   = {16'h0000, 16'h9999};
    fork
      expect_slot(0, 16'h1111, 16'h2222, 1'b0, 2'd0, "R7 old word sent");
      begin @(negedge clk); wr_strobe = '0; end
    join
    idle_check(5, "R6 lane1 empty blocks");
    chk(empty_o == 2'b10, "R7 write at launch kept", 64'(empty_o), 64'd2);
    write_lanes(2'b10, 16'h0000, 16'h4444);
    expect_slot(0, 16'h9999, 16'h4444, 1'b0, 2'd0, "R7 new word follows");
    idle_check(3, "R5 idle");
  endtask

  task automatic t_back_to_back(input logic [1:0] code, input int d);
    dly_sel = code;
    write_lanes(2'b11, 16'hF00F, 16'h0FF0);
    fork
      expect_slot(d, 16'hF00F, 16'h0FF0, 1'b0, 2'd0, "R9 first slot");
      begin repeat (3) @(negedge clk); write_lanes(2'b11, 16'h6A6A, 16'hA6A6); end
    join
    expect_slot(d, 16'h6A6A, 16'hA6A6, 1'b0, 2'd0, "R9 no gap");
    idle_check(4, "R5 idle after stream");
  endtask

  task automatic t_delay_change;
    dly_sel = 2'd2;
    write_lanes(2'b11, 16'hABCD, 16'h4321);
    expect_slot(2, 16'hABCD, 16'h4321, 1'b1, 2'd0, "R8 delay held in slot");
    write_lanes(2'b11, 16'h00FF, 16'hFF00);
    expect_slot(0, 16'h00FF, 16'hFF00, 1'b0, 2'd0, "R8 new delay next slot");
    idle_check(3, "R5 idle");
  endtask

  task automatic t_none_enabled;
    lane_en = 2'b00;
    write_lanes(2'b11, 16'h1357, 16'h2468);
    idle_check(10, "R6 no lane enabled");
    lane_en = 2'b11;
    expect_slot(0, 16'h1357, 16'h2468, 1'b0, 2'd0, "R2 launch on enable");
    idle_check(3, "R5 idle");
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delay(2'd1, 1, "R4 delay1");
    t_delay(2'd2, 2, "R4 delay2");
    t_delay(2'd3, 2, "R4 code3 as 2");
    t_partial();
    t_disabled();
    t_coincide();
    t_back_to_back(2'd0, 0);
    t_back_to_back(2'd2, 2);
    t_delay_change();
    t_none_enabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule